// File: doc/BRIEF.md
# Triangle-Wave Spread Spectrum Modulator

This block produces the divide value that a fractional-N feedback divider uses on each of its output cycles. It sweeps that value in a linear triangle so that the synthesized clock has its frequency spread. The top of the triangle is a fixed-point number programmed as an 8-bit integer part and a 16-bit fraction. From that top the value falls by a programmed step on every divider tick for a programmed number of ticks. It then climbs back by the same step for the same number of ticks and repeats. The value therefore never rises above the programmed top. To get a symmetric (centre) spread, software programs a top that is lower by half the peak-to-peak spread. The ramp itself is the same in both cases.

Software programs the block through a byte-wide register bank with a write strobe and a combinational readback. Any write to a mapped byte, and any time the block is disabled, returns the sweep to the top value and sets it falling again. The `tick` input marks one cycle of the divider output. Between ticks the output holds.

Top module: `tri_spread_gen`

## Requirements
- R1: After reset every register byte reads 0x00 and `div_value` is 0.
- R2: Register map (address: content): 0x10 bit 7 = enable, bits 3:0 = half-period bits 11:8, bits 6:4 read 0. 0x11 = half-period bits 7:0. 0x12 = integer part of the top value. 0x13 = fraction bits 15:8. 0x14 = fraction bits 7:0. 0x15 = step bits 15:8. 0x16 = step bits 7:0. Each byte reads back what was written.
- R3: Addresses outside 0x10..0x16 read 0x00. A write to them changes no register and does not disturb the sweep.
- R4: While enable is 0, `div_value` equals the top value {integer, fraction} (24 bits, 16 fraction bits), whatever the ticks, half-period and step.
- R5: `div_value` is never greater than the top value.
- R6: With enable 1, half-period N and step S, the k-th tick of a sweep (k ≤ N) gives top − k·S. The next N ticks rise by S each, so the value is the top again after 2N ticks, and the pattern repeats. A half-period of 0 acts as 1.
- R7: `div_value` changes only on a clock edge where `tick` is 1 or a mapped write occurs.
- R8: A write to any mapped byte restarts the sweep. At the next sample, `div_value` equals the new top value, and the next tick moves it down.
- R9: When the distance swept below the top exceeds the top value, `div_value` is held at 0 instead of wrapping.
- R10: The largest half-period (4095) with the largest step (0xFFFF) sweeps without wrapping the internal accumulator and returns exactly to the top.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One divider-output cycle has elapsed |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register readback for `reg_addr` |
| div_value | output | 24 | Modulated divide value, 8.16 fixed point |

## Verification
The hardest state to reach is a sweep that has gone past the top value. It only occurs when a small top is combined with a large step, or when the largest half-period is combined with the largest step. In the second case thousands of consecutive ticks must arrive before the accumulator reaches its peak and comes back. The stimulus programs both corners directly. It drives unbroken tick runs long enough to cross zero, sit there, and climb back to the exact top. Throughout, a behavioural model running on wide integers is compared against the output on every clock.

// File: rtl/tsg_pkg.sv
package tsg_pkg;
    localparam int INT_W  = 8;
    localparam int FRAC_W = 16;
    localparam int PER_W  = 12;
    localparam int STEP_W = 16;
    localparam int VAL_W  = INT_W + FRAC_W;
    localparam int ACC_W  = PER_W + STEP_W;   // period x step cannot wrap
    localparam int PER_HI_W = PER_W - 8;

    typedef struct packed {
        logic              en;
        logic [PER_W-1:0]  half_per;
        logic [INT_W-1:0]  int_part;
        logic [FRAC_W-1:0] frac_part;
        logic [STEP_W-1:0] step;
    } tsg_cfg_t;

    typedef struct packed {
        logic [ACC_W-1:0] depth;   // distance below the top value
        logic             falling;
        logic [PER_W-1:0] cnt;     // ticks spent in current half
    } tsg_ramp_t;
endpackage

// File: rtl/tsg_regs.sv
module tsg_regs
    import tsg_pkg::*;
#(
    parameter logic [7:0] BASE_ADDR = 8'h10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic [7:0] addr,
    input  logic [7:0] wdata,
    output tsg_cfg_t   cfg,
    output logic [7:0] rdata,
    output logic       restart
);
    localparam logic [7:0] A_CTL = BASE_ADDR;
    localparam logic [7:0] A_PLO = BASE_ADDR + 8'd1;
    localparam logic [7:0] A_INT = BASE_ADDR + 8'd2;
    localparam logic [7:0] A_FHI = BASE_ADDR + 8'd3;
    localparam logic [7:0] A_FLO = BASE_ADDR + 8'd4;
    localparam logic [7:0] A_SHI = BASE_ADDR + 8'd5;
    localparam logic [7:0] A_SLO = BASE_ADDR + 8'd6;

    tsg_cfg_t cfg_d, cfg_q;
    logic     hit_d;

    always_comb begin
        cfg_d = cfg_q;
        hit_d = 1'b0;
        if (wr) begin
            hit_d = 1'b1;
            case (addr)
                A_CTL: begin
                    cfg_d.en = wdata[7];
                    cfg_d.half_per[PER_W-1:8] = wdata[PER_HI_W-1:0];
                end
                A_PLO: cfg_d.half_per[7:0]   = wdata;
                A_INT: cfg_d.int_part        = wdata;
                A_FHI: cfg_d.frac_part[15:8] = wdata;
                A_FLO: cfg_d.frac_part[7:0]  = wdata;
                A_SHI: cfg_d.step[15:8]      = wdata;
                A_SLO: cfg_d.step[7:0]       = wdata;
                default: hit_d = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        case (addr)
            A_CTL:   rdata = {cfg_q.en, {(7-PER_HI_W){1'b0}}, cfg_q.half_per[PER_W-1:8]};
            A_PLO:   rdata = cfg_q.half_per[7:0];
            A_INT:   rdata = cfg_q.int_part;
            A_FHI:   rdata = cfg_q.frac_part[15:8];
            A_FLO:   rdata = cfg_q.frac_part[7:0];
            A_SHI:   rdata = cfg_q.step[15:8];
            A_SLO:   rdata = cfg_q.step[7:0];
            default: rdata = 8'h00;
        endcase
    end

    assign cfg     = cfg_q;
    assign restart = hit_d;
endmodule

// File: rtl/tsg_ramp.sv
module tsg_ramp
    import tsg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             restart,
    input  tsg_cfg_t         cfg,
    output logic [VAL_W-1:0] value
);
    tsg_ramp_t st_d, st_q;

    logic [ACC_W-1:0] top_ext;
    logic [ACC_W-1:0] step_ext;
    logic [PER_W:0]   cnt_next;
    logic             half_done;

    assign top_ext   = ACC_W'({cfg.int_part, cfg.frac_part});
    assign step_ext  = ACC_W'(cfg.step);
    assign cnt_next  = {1'b0, st_q.cnt} + {{PER_W{1'b0}}, 1'b1};
    assign half_done = cnt_next >= {1'b0, cfg.half_per};

    always_comb begin
        st_d = st_q;
        if (restart || !cfg.en) begin
            st_d.depth   = '0;
            st_d.falling = 1'b1;
            st_d.cnt     = '0;
        end else if (tick) begin
            if (st_q.falling)
                st_d.depth = st_q.depth + step_ext;
            else if (st_q.depth < step_ext)
                st_d.depth = '0;
            else
                st_d.depth = st_q.depth - step_ext;
            if (half_done) begin
                st_d.cnt     = '0;
                st_d.falling = !st_q.falling;
            end else begin
                st_d.cnt = cnt_next[PER_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{depth: '0, falling: 1'b1, cnt: '0};
        else        st_q <= st_d;
    end

    always_comb begin
        if (st_q.depth > top_ext) value = '0;
        else                      value = VAL_W'(top_ext - st_q.depth);
    end
endmodule

// File: rtl/tri_spread_gen.sv
module tri_spread_gen
    import tsg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             reg_wr,
    input  logic [7:0]       reg_addr,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    output logic [VAL_W-1:0] div_value
);
    tsg_cfg_t         cfg;
    logic             restart;
    logic             en_w;
    logic [VAL_W-1:0] top_val;

    tsg_regs #(.BASE_ADDR(8'h10)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .cfg(cfg), .rdata(reg_rdata), .restart(restart)
    );

    tsg_ramp ramp_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .restart(restart),
        .cfg(cfg), .value(div_value)
    );

    assign en_w    = cfg.en;
    assign top_val = {cfg.int_part, cfg.frac_part};
endmodule

// File: rtl/tsg_checker.sv
module tsg_checker #(
    parameter int VAL_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             reg_wr,
    input logic [7:0]       reg_addr,
    input logic [7:0]       reg_rdata,
    input logic             en,
    input logic [VAL_W-1:0] top_val,
    input logic [VAL_W-1:0] div_value
);
    logic mapped;
    assign mapped = (reg_addr >= 8'h10) && (reg_addr <= 8'h16);

    a_r5_never_above_top: assert property (@(posedge clk) disable iff (!rst_n)
        div_value <= top_val);

    a_r4_idle_tracks_top: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> div_value == top_val);

    a_r7_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !reg_wr) |=> $stable(div_value));

    a_r8_write_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && mapped) |=> div_value == top_val);

    a_r3_unmapped_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !mapped |-> reg_rdata == 8'h00);
endmodule

bind tri_spread_gen tsg_checker #(.VAL_W(tsg_pkg::VAL_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_rdata(reg_rdata), .en(en_w),
    .top_val(top_val), .div_value(div_value)
);

// File: tb/tri_spread_gen_tb_top.sv
module tri_spread_gen_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [7:0]  reg_wdata = 8'h00;
    logic [7:0]  reg_rdata;
    logic [23:0] div_value;

    int    n_checks = 0;
    int    n_fail = 0;
    string cur_req = "R1";
    bit    done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tri_spread_gen dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .div_value(div_value)
    );

    // behavioural reference model
    bit     m_en;
    int     m_per, m_int, m_frac, m_step, m_pos;
    longint m_depth;
    bit     m_fall;

    function automatic longint m_top();
        return longint'(m_int) * 65536 + longint'(m_frac);
    endfunction

    function automatic longint m_out();
        return (m_depth > m_top()) ? 0 : m_top() - m_depth;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = 0; m_per = 0; m_int = 0; m_frac = 0; m_step = 0;
            m_depth = 0; m_fall = 1; m_pos = 0;
        end else if (reg_wr && reg_addr >= 8'h10 && reg_addr <= 8'h16) begin
            case (reg_addr)
                8'h10: begin m_en = reg_wdata[7]; m_per = (m_per % 256) + int'(reg_wdata[3:0]) * 256; end
                8'h11: m_per = (m_per / 256) * 256 + int'(reg_wdata);
                8'h12: m_int = int'(reg_wdata);
                8'h13: m_frac = (m_frac % 256) + int'(reg_wdata) * 256;
                8'h14: m_frac = (m_frac / 256) * 256 + int'(reg_wdata);
                8'h15: m_step = (m_step % 256) + int'(reg_wdata) * 256;
                default: m_step = (m_step / 256) * 256 + int'(reg_wdata);
            endcase
            m_depth = 0; m_fall = 1; m_pos = 0;
        end else if (!m_en) begin
            m_depth = 0; m_fall = 1; m_pos = 0;
        end else if (tick) begin
            if (m_fall) m_depth = m_depth + m_step;
            else        m_depth = (m_depth < m_step) ? 0 : m_depth - m_step;
            m_pos++;
            if (m_pos >= m_per) begin m_pos = 0; m_fall = !m_fall; end
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // compare with the model on every clock
    always @(negedge clk) begin
        if (rst_n && !done)
            chk(longint'(div_value) == m_out(), cur_req, longint'(div_value), m_out());
    end

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        tick = 0; reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string req);
        reg_addr = a;
        #1;
        chk(reg_rdata == exp, req, longint'(reg_rdata), longint'(exp));
    endtask

    task automatic ticks(input int n, input int density);
        for (int i = 0; i < n; i++) begin
            tick = ($urandom % 100) < density;
            @(negedge clk);
        end
        tick = 0;
    endtask

    task automatic setup(input int ip, input int fr, input int st, input int per, input bit en);
        wr(8'h12, ip[7:0]);
        wr(8'h13, fr[15:8]);
        wr(8'h14, fr[7:0]);
        wr(8'h15, st[15:8]);
        wr(8'h16, st[7:0]);
        wr(8'h11, per[7:0]);
        wr(8'h10, {en, 3'b000, per[11:8]});
    endtask

    task automatic val(input longint exp, input string req);
        chk(longint'(div_value) == exp, req, longint'(div_value), exp);
    endtask

    task automatic finish_run();
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        cur_req = "R1";
        val(0, "R1");
        for (int a = 8'h10; a <= 8'h16; a++) rd(a[7:0], 8'h00, "R1");

        // R2 map and readback
        cur_req = "R2";
        setup(8'h40, 16'h8000, 16'h0123, 5, 1'b0);
        wr(8'h10, 8'hFF);
        rd(8'h10, 8'h8F, "R2");
        rd(8'h11, 8'h05, "R2");
        rd(8'h12, 8'h40, "R2");
        rd(8'h13, 8'h80, "R2");
        rd(8'h14, 8'h00, "R2");
        rd(8'h15, 8'h01, "R2");
        rd(8'h16, 8'h23, "R2");
        wr(8'h10, 8'h00);

        // R4 disabled output equals top
        cur_req = "R4";
        ticks(20, 100);
        val(64'h408000, "R4");

        // R6 exact ramp, half-period 5, step 0x123
        cur_req = "R6";
        wr(8'h10, 8'h80);
        ticks(3, 100); val(64'h407C97, "R6");
        ticks(2, 100); val(64'h407A51, "R6");
        ticks(1, 100); val(64'h407B74, "R6");
        ticks(4, 100); val(64'h408000, "R6");
        ticks(10, 100); val(64'h408000, "R6");

        // R3 unmapped access does not disturb the sweep
        cur_req = "R3";
        ticks(2, 100);
        wr(8'h17, 8'hAA);
        wr(8'h0F, 8'h55);
        val(64'h408000 - 2 * 64'h123, "R3");
        rd(8'h17, 8'h00, "R3");
        rd(8'h0F, 8'h00, "R3");
        rd(8'hFF, 8'h00, "R3");
        rd(8'h12, 8'h40, "R3");

        // R8 mapped write restarts at top
        cur_req = "R8";
        ticks(1, 100);
        wr(8'h16, 8'h00);
        wr(8'h15, 8'h02);
        val(64'h408000, "R8");
        ticks(1, 100); val(64'h408000 - 64'h200, "R8");

        // R7 sparse ticks, output holds between them
        cur_req = "R7";
        ticks(300, 35);
        cur_req = "R5";
        ticks(300, 80);

        // R6 half-period 0 behaves as 1
        cur_req = "R6";
        wr(8'h11, 8'h00);
        wr(8'h10, 8'h80);
        ticks(1, 100); val(64'h408000 - 64'h200, "R6");
        ticks(1, 100); val(64'h408000, "R6");

        // R9 clamp at zero
        cur_req = "R9";
        setup(8'h00, 16'h0100, 16'h0100, 4, 1'b1);
        ticks(2, 100); val(0, "R9");
        ticks(5, 100); val(0, "R9");
        ticks(1, 100); val(64'h100, "R9");

        // R10 largest half-period and step
        cur_req = "R10";
        setup(8'hFF, 16'hFFFF, 16'hFFFF, 12'hFFF, 1'b1);
        ticks(255, 100); val(64'h100FE, "R10");
        ticks(3840, 100); val(0, "R10");
        ticks(4095, 100); val(64'hFFFFFF, "R10");
        ticks(2, 100);

        finish_run();
    end
endmodule